// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a single-level, direct-mapped data cache. It sits between a small set of requesters and a slower memory that moves whole lines. Each requester presents a word address, a write flag and write data, and holds its request steady. Every cycle, each requester receives a two-bit status: idle, WAIT, BLOCKED or OK. Only one requester, the owner, is served at a time. Writes update one word of a cached line and mark the line dirty. They are not forwarded to memory. A completed read returns the whole line.

On a miss, the cache first writes back the victim line if it is valid and dirty. It then fetches the requested line from the lower memory and reports BLOCKED until the fetch completes. A programmable hit latency is counted only while the owner is not waiting on memory. A latency of zero lets a hit finish in the same cycle it is presented.

Top module: `dm_wb_cache`

## Requirements
- R1: A request address is split into a word offset in bits 1:0, a line index in bits 6:2 and a tag in bits 19:7. A line holds 4 words of 32 bits, and word w sits at bits 32w+31:32w of a line bus. The lower-memory line address is {tag, index}.
- R2: After reset, every line is invalid and clean. The first access to any address is therefore a miss. While no request is present, every status is idle (2'b00), mem_req is low and rd_line is zero.
- R3: When no owner is held, the requester with the lowest index among those presenting becomes owner. It stays owner up to and including its OK cycle. Every other presenting requester receives WAIT (2'b01) throughout.
- R4: On a miss with a clean or invalid victim, the cache holds a line read (mem_req=1, mem_we=0) at {tag, index} and returns BLOCKED (2'b10) to the owner. This continues in every cycle until a cycle in which mem_ok is high. The returned line is then installed as valid and clean.
- R5: A latency counter, loaded with HIT_LAT, decrements at each clock edge on which the owner is not blocked. The cycle in which a fill's mem_ok arrives counts as not blocked. The owner receives OK (2'b11) in the first not-blocked cycle in which the counter is zero. Before that cycle it receives WAIT.
- R6: A completing write replaces only the addressed word and marks the line dirty. It causes no memory request.
- R7: After an OK, the owner is released at the next clock edge and the counter is reloaded. With HIT_LAT=0, a hit returns OK in the cycle it is presented.
- R8: In the OK cycle of a read, rd_line carries the full line, including a line that is being filled in that cycle. In every other cycle, rd_line is zero.
- R9: On a miss whose victim is valid and dirty, the cache first holds a line write (mem_we=1) of the victim's stored data to {victim tag, index} and reports BLOCKED. When mem_ok arrives, the victim is made clean, and the line read of R4 follows in the next cycle.
- R10: At most one requester receives OK in any cycle.
- R11: A waiting requester that addresses the line just filled hits after the owner is released. A waiting requester that addresses a different index goes through its own fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Per-requester request present, held until OK |
| req_write | input | NREQ | Per-requester write (1) or line read (0) |
| req_addr | input | NREQ*ADDR_W | Per-requester word address, requester i at slice i |
| req_wdata | input | NREQ*DATA_W | Per-requester write word |
| resp | output | 2*NREQ | Per-requester status: 00 idle, 01 WAIT, 10 BLOCKED, 11 OK |
| rd_line | output | LINE_W | Line returned in a read's OK cycle, zero otherwise |
| mem_req | output | 1 | Lower-memory transfer request, held until mem_ok |
| mem_we | output | 1 | Transfer is a line write-back |
| mem_addr | output | TAG_W+IDX_W | Line address {tag, index} |
| mem_wline | output | LINE_W | Victim line data for a write-back |
| mem_ok | input | 1 | Lower memory completes the current transfer this cycle |
| mem_rline | input | LINE_W | Line data returned with mem_ok on a read |

## Verification
Two simultaneous writes to one line separate lowest-index ownership and the same-line hit after release. Writes and reads to neighbouring indexes show that a waiter on another index pays its own fill. A read that evicts a line holding two fresh writes, followed by a re-read of the evicted address, separates the write-back ordering and the absence of write-through from a plain refill. A long mixed stream over three tags and four indexes from all requesters is run at hit latencies of zero and two. The zero-latency run exposes same-cycle completion, including completion on the fill cycle, and the two-cycle run exposes counter freezing while memory is busy.

// File: rtl/dwc_pkg.sv
// Shared definitions for the direct-mapped write-back cache.
// Assumes: per-requester status is a two-bit code.
package dwc_pkg;

    // Status code returned to each requester every cycle.
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'b00,
        RSP_WAIT  = 2'b01,
        RSP_BLOCK = 2'b10,
        RSP_OK    = 2'b11
    } rsp_e;

endpackage

// File: rtl/dwc_owner_arb.sv
// Owner arbiter: keeps the current owner until it completes. When free,
// it picks the lowest-indexed presenting requester.
// Assumes: an owner holds its request until it receives OK.
module dwc_owner_arb #(
    parameter int NREQ = 3,
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_valid,
    input  logic            release_i,
    output logic            own_valid,
    output logic [ID_W-1:0] own_id
);

    logic            held_q;
    logic [ID_W-1:0] held_id_q;
    logic [ID_W-1:0] pick_id;

    // Lowest-index presenting requester wins a free cache.
    always_comb begin
        pick_id = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req_valid[i]) pick_id = ID_W'(i);
        end
    end

    assign own_valid = held_q | (|req_valid);
    assign own_id    = held_q ? held_id_q : pick_id;

    // Hold ownership until the completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= 1'b0;
            held_id_q <= '0;
        end else if (release_i) begin
            held_q    <= 1'b0;
        end else begin
            held_q    <= own_valid;
            held_id_q <= own_id;
        end
    end

endmodule

// File: rtl/dwc_line_store.sv
// Line store: per-line valid, dirty, tag and data, with one combinational
// read port and one write port.
// Assumes: data and tags need no reset; valid and dirty are cleared.
module dwc_line_store #(
    parameter int IDX_W  = 5,
    parameter int TAG_W  = 13,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dirty,
    input  logic [LINE_W-1:0] wr_line
);

    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = data_q[rd_idx];

    // Line state flags: cleared by reset, set by each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    // Tag and data arrays.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_line;
        end
    end

endmodule

// File: rtl/dwc_ctrl.sv
// Access controller: decides hit or miss for the owner's request.
// It sequences write-back and fill on the lower memory, runs the latency
// counter, and forms the line-store update and read return.
// Assumes: the lower memory holds its answer until mem_req and signals
// completion with a one-cycle mem_ok.
module dwc_ctrl #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 2,
    parameter int IDX_W   = 5,
    parameter int TAG_W   = 13,
    parameter int LINE_W  = 128,
    parameter int HIT_LAT = 1,
    parameter int CNT_W   = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   own_valid,
    input  logic                   own_write,
    input  logic [ADDR_W-1:0]      own_addr,
    input  logic [DATA_W-1:0]      own_wdata,
    input  logic                   meta_valid,
    input  logic                   meta_dirty,
    input  logic [TAG_W-1:0]       meta_tag,
    input  logic [LINE_W-1:0]      meta_line,
    input  logic                   mem_ok,
    input  logic [LINE_W-1:0]      mem_rline,
    output logic [IDX_W-1:0]       own_idx,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [TAG_W+IDX_W-1:0] mem_addr,
    output logic [LINE_W-1:0]      mem_wline,
    output logic                   wr_en,
    output logic [TAG_W-1:0]       wr_tag,
    output logic                   wr_dirty,
    output logic [LINE_W-1:0]      wr_line,
    output logic                   acc_ready,
    output logic                   acc_done,
    output logic [LINE_W-1:0]      rd_line
);

    localparam int WORDS = 1 << OFS_W;
    localparam logic [CNT_W-1:0] LAT_INIT = CNT_W'(HIT_LAT);

    logic [OFS_W-1:0]  own_off;
    logic [TAG_W-1:0]  own_tag;
    logic              hit;
    logic              wb_phase;
    logic              fill_phase;
    logic              fill_done;
    logic [LINE_W-1:0] base_line;
    logic [LINE_W-1:0] merged_line;
    logic [CNT_W-1:0]  cnt_q;

    // Address fields: offset, index, tag from low to high.
    assign own_off = own_addr[OFS_W-1:0];
    assign own_idx = own_addr[OFS_W +: IDX_W];
    assign own_tag = own_addr[ADDR_W-1 -: TAG_W];

    // Miss classification against the indexed line.
    assign hit        = meta_valid && (meta_tag == own_tag);
    assign wb_phase   = own_valid && !hit && meta_valid && meta_dirty;
    assign fill_phase = own_valid && !hit && !(meta_valid && meta_dirty);
    assign fill_done  = fill_phase && mem_ok;

    // Lower-memory request: write-back of the victim first, then the fill.
    assign mem_req   = wb_phase || fill_phase;
    assign mem_we    = wb_phase;
    assign mem_addr  = wb_phase ? {meta_tag, own_idx} : {own_tag, own_idx};
    assign mem_wline = meta_line;

    // Access may progress on a hit or on the cycle a fill returns.
    assign acc_ready = own_valid && (hit || fill_done);
    assign acc_done  = acc_ready && (cnt_q == '0);

    assign base_line = fill_done ? mem_rline : meta_line;

    // Word merge for a completing write.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign merged_line[w*DATA_W +: DATA_W] =
            (own_off == OFS_W'(w)) ? own_wdata : base_line[w*DATA_W +: DATA_W];
    end

    // Line-store update: victim cleaned, line installed, or word written.
    always_comb begin
        wr_en    = (wb_phase && mem_ok) || fill_done || (acc_done && own_write);
        wr_tag   = wb_phase ? meta_tag : own_tag;
        wr_dirty = acc_done && own_write;
        if (acc_done && own_write) begin
            wr_line = merged_line;
        end else if (fill_done) begin
            wr_line = mem_rline;
        end else begin
            wr_line = meta_line;
        end
    end

    // Read return only in a read's completing cycle.
    assign rd_line = (acc_done && !own_write) ? base_line : '0;

    // Latency counter: frozen while blocked, reloaded on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAT_INIT;
        end else if (acc_done) begin
            cnt_q <= LAT_INIT;
        end else if (acc_ready && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/dm_wb_cache.sv
// Direct-mapped write-back cache top: connects the owner arbiter, the
// line store and the access controller, and fans out per-requester status.
// Assumes: requesters hold address, write flag and data until OK.
module dm_wb_cache #(
    parameter int NREQ    = 3,
    parameter int DATA_W  = 32,
    parameter int OFS_W   = 2,
    parameter int IDX_W   = 5,
    parameter int TAG_W   = 13,
    parameter int HIT_LAT = 1,
    localparam int ADDR_W  = OFS_W + IDX_W + TAG_W,
    localparam int LINE_W  = (1 << OFS_W) * DATA_W,
    localparam int LADDR_W = TAG_W + IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREQ-1:0]        req_valid,
    input  logic [NREQ-1:0]        req_write,
    input  logic [NREQ*ADDR_W-1:0] req_addr,
    input  logic [NREQ*DATA_W-1:0] req_wdata,
    output logic [2*NREQ-1:0]      resp,
    output logic [LINE_W-1:0]      rd_line,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [LADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]      mem_wline,
    input  logic                   mem_ok,
    input  logic [LINE_W-1:0]      mem_rline
);

    import dwc_pkg::*;

    localparam int ID_W  = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int CNT_W = (HIT_LAT > 0) ? $clog2(HIT_LAT + 1) : 1;

    logic              own_valid;
    logic [ID_W-1:0]   own_id;
    logic              own_write;
    logic [ADDR_W-1:0] own_addr;
    logic [DATA_W-1:0] own_wdata;
    logic [IDX_W-1:0]  own_idx;
    logic              meta_valid;
    logic              meta_dirty;
    logic [TAG_W-1:0]  meta_tag;
    logic [LINE_W-1:0] meta_line;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic              wr_dirty;
    logic [LINE_W-1:0] wr_line;
    logic              acc_ready;
    logic              acc_done;

    dwc_owner_arb #(
        .NREQ (NREQ),
        .ID_W (ID_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .release_i (acc_done),
        .own_valid (own_valid),
        .own_id    (own_id)
    );

    // Select the owner's request fields.
    always_comb begin
        own_write = 1'b0;
        own_addr  = '0;
        own_wdata = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (own_id == ID_W'(i)) begin
                own_write = req_write[i];
                own_addr  = req_addr[i*ADDR_W +: ADDR_W];
                own_wdata = req_wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    dwc_line_store #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (own_idx),
        .rd_valid (meta_valid),
        .rd_dirty (meta_dirty),
        .rd_tag   (meta_tag),
        .rd_line  (meta_line),
        .wr_en    (wr_en),
        .wr_idx   (own_idx),
        .wr_tag   (wr_tag),
        .wr_dirty (wr_dirty),
        .wr_line  (wr_line)
    );

    dwc_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .OFS_W   (OFS_W),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .LINE_W  (LINE_W),
        .HIT_LAT (HIT_LAT),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .own_valid  (own_valid),
        .own_write  (own_write),
        .own_addr   (own_addr),
        .own_wdata  (own_wdata),
        .meta_valid (meta_valid),
        .meta_dirty (meta_dirty),
        .meta_tag   (meta_tag),
        .meta_line  (meta_line),
        .mem_ok     (mem_ok),
        .mem_rline  (mem_rline),
        .own_idx    (own_idx),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wline  (mem_wline),
        .wr_en      (wr_en),
        .wr_tag     (wr_tag),
        .wr_dirty   (wr_dirty),
        .wr_line    (wr_line),
        .acc_ready  (acc_ready),
        .acc_done   (acc_done),
        .rd_line    (rd_line)
    );

    // Per-requester status code.
    for (genvar g = 0; g < NREQ; g++) begin : g_rsp
        rsp_e code;
        always_comb begin
            if (!req_valid[g]) begin
                code = RSP_IDLE;
            end else if (!(own_valid && (own_id == ID_W'(g)))) begin
                code = RSP_WAIT;
            end else if (acc_done) begin
                code = RSP_OK;
            end else if (!acc_ready) begin
                code = RSP_BLOCK;
            end else begin
                code = RSP_WAIT;
            end
        end
        assign resp[2*g +: 2] = code;
    end

endmodule

// File: rtl/dwc_checker.sv
// Protocol checker for the cache top, attached by bind.
// Assumes: requesters and memory follow the hold-until-done handshake.
module dwc_checker #(
    parameter int NREQ    = 3,
    parameter int ID_W    = 2,
    parameter int LINE_W  = 128,
    parameter int LADDR_W = 18
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*NREQ-1:0]  resp,
    input logic [LINE_W-1:0]  rd_line,
    input logic               mem_req,
    input logic               mem_we,
    input logic [LADDR_W-1:0] mem_addr,
    input logic               mem_ok,
    input logic               own_valid,
    input logic [ID_W-1:0]    own_id
);

    logic [NREQ-1:0] ok_vec;
    logic [NREQ-1:0] blk_vec;

    // Decode status codes per requester.
    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            ok_vec[i]  = (resp[2*i +: 2] == 2'b11);
            blk_vec[i] = (resp[2*i +: 2] == 2'b10);
        end
    end

    p_one_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ok_vec) <= 1);

    p_owner_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_valid && (ok_vec == '0)) |=> (own_valid && (own_id == $past(own_id))));

    p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ok) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_blocked_no_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_vec != '0) |-> (ok_vec == '0));

    p_wb_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (blk_vec != '0));

    p_fill_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ok) |=> (mem_req && !mem_we));

    p_line_only_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_line != '0) |-> (ok_vec != '0));

endmodule

bind dm_wb_cache dwc_checker #(
    .NREQ    (NREQ),
    .ID_W    (ID_W),
    .LINE_W  (LINE_W),
    .LADDR_W (LADDR_W)
) u_dwc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .resp      (resp),
    .rd_line   (rd_line),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ok    (mem_ok),
    .own_valid (own_valid),
    .own_id    (own_id)
);

// File: tb/dm_wb_cache_env.sv
// One cache instance with a behavioural lower memory and a cycle-level
// reference model, compared on every clock.
module dm_wb_cache_env #(
    parameter int LAT  = 0,
    parameter int MLAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   n_vec,
    output int   n_err
);

    localparam int NREQ = 3;
    localparam int AW   = 20;
    localparam int DW   = 32;
    localparam int LW   = 128;

    typedef struct {
        bit          w;
        int          a;
        logic [31:0] d;
    } op_t;

    logic [NREQ-1:0]    req_valid;
    logic [NREQ-1:0]    req_write;
    logic [NREQ*AW-1:0] req_addr;
    logic [NREQ*DW-1:0] req_wdata;
    logic [2*NREQ-1:0]  resp;
    logic [LW-1:0]      rd_line;
    logic               mem_req;
    logic               mem_we;
    logic [17:0]        mem_addr;
    logic [LW-1:0]      mem_wline;
    logic               mem_ok;
    logic [LW-1:0]      mem_rline;

    dm_wb_cache #(.NREQ(NREQ), .HIT_LAT(LAT)) u_dm_wb_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .resp      (resp),
        .rd_line   (rd_line),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wline (mem_wline),
        .mem_ok    (mem_ok),
        .mem_rline (mem_rline)
    );

    op_t           oq [NREQ][$];
    logic [LW-1:0] mem_store [int];
    int            m_tag   [32];
    bit            m_dirty [32];
    logic [LW-1:0] m_line  [32];
    int            m_owner;
    int            m_cnt;
    int            mcnt;
    int            cyc;

    function automatic logic [LW-1:0] mem_get(int la);
        logic [LW-1:0] v;
        if (mem_store.exists(la)) return mem_store[la];
        for (int w = 0; w < 4; w++) v[w*32 +: 32] = {8'h5A, 4'(w), 20'(la)};
        return v;
    endfunction

    task automatic chk(string rq, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s (lat %0d): actual %h expected %h", rq, what, LAT, act, exp);
        end
    endtask

    task automatic put(int r, bit w, int a, logic [31:0] d);
        op_t o;
        o.w = w; o.a = a; o.d = d;
        oq[r].push_back(o);
    endtask

    function automatic int pending();
        int n = 0;
        for (int i = 0; i < NREQ; i++) n += oq[i].size();
        return n;
    endfunction

    // One clock: drive, predict, compare, commit model state.
    task automatic step();
        int own, idx, tg, off, ex_la;
        int ex [NREQ];
        bit ex_req, ex_we, fill_ok, wb_ok, ready, acc_ok;
        logic [LW-1:0] ex_wl, ex_rd, base;
        op_t op;
        @(negedge clk);
        cyc++;
        for (int i = 0; i < NREQ; i++) begin
            if (oq[i].size() > 0) begin
                req_valid[i] = 1'b1;
                req_write[i] = oq[i][0].w;
                req_addr[i*AW +: AW]  = 20'(oq[i][0].a);
                req_wdata[i*DW +: DW] = oq[i][0].d;
            end else begin
                req_valid[i] = 1'b0;
                req_write[i] = 1'b0;
            end
        end
        own = m_owner;
        if (own < 0) begin
            for (int i = 0; i < NREQ; i++) if (own < 0 && req_valid[i]) own = i;
        end
        for (int i = 0; i < NREQ; i++) ex[i] = req_valid[i] ? 1 : 0;
        ex_req = 0; ex_we = 0; ex_la = 0; ex_wl = '0; ex_rd = '0; base = '0;
        fill_ok = 0; wb_ok = 0; ready = 0; acc_ok = 0; idx = 0; tg = 0; off = 0;
        mem_ok = 1'b0;
        mem_rline = '0;
        if (own >= 0) begin
            op  = oq[own][0];
            off = op.a & 3;            // R1 offset bits 1:0
            idx = (op.a >> 2) & 31;    // R1 index bits 6:2
            tg  = (op.a >> 7) & 8191;  // R1 tag bits 19:7
            if (m_tag[idx] != tg) begin
                ex_req = 1;
                if (m_tag[idx] >= 0 && m_dirty[idx]) begin
                    ex_we = 1;
                    ex_la = m_tag[idx] * 32 + idx;
                    ex_wl = m_line[idx];
                end else begin
                    ex_la = tg * 32 + idx;
                end
                mem_ok = (mcnt == MLAT);
                if (!ex_we) mem_rline = mem_get(ex_la);
                wb_ok   = ex_we && mem_ok;
                fill_ok = !ex_we && mem_ok;
            end
            ready = (m_tag[idx] == tg) || fill_ok;
            base  = fill_ok ? mem_get(ex_la) : m_line[idx];
            if (!ready) ex[own] = 2;
            else if (m_cnt == 0) begin ex[own] = 3; acc_ok = 1; end
            else ex[own] = 1;
            if (acc_ok && !op.w) ex_rd = base;
        end
        #1;
        // Status codes: WAIT checks R3, BLOCKED R4, OK R5/R7, idle R10
        for (int i = 0; i < NREQ; i++) begin
            string rq;
            rq = (ex[i] == 1) ? "R3" : (ex[i] == 2) ? "R4" : (ex[i] == 3) ? "R5" : "R10";
            chk(rq, $sformatf("status of requester %0d", i), LW'(resp[2*i +: 2]), LW'(ex[i]));
        end
        chk("R6", "mem_req", LW'(mem_req), LW'(ex_req));
        if (ex_req) begin
            chk("R9", "mem_we", LW'(mem_we), LW'(ex_we));
            chk("R4", "mem_addr", LW'(mem_addr), LW'(ex_la));
            if (ex_we) chk("R9", "mem_wline", mem_wline, ex_wl);
        end
        chk("R8", "rd_line", rd_line, ex_rd);
        // Commit.
        if (wb_ok) begin mem_store[ex_la] = ex_wl; m_dirty[idx] = 0; end
        if (fill_ok) begin m_tag[idx] = tg; m_line[idx] = base; m_dirty[idx] = 0; end
        if (acc_ok) begin
            if (op.w) begin m_line[idx][off*32 +: 32] = op.d; m_dirty[idx] = 1; end
            void'(oq[own].pop_front());
            m_owner = -1;
            m_cnt   = LAT;             // R7 reload on release
        end else begin
            m_owner = own;
            if (ready && m_cnt > 0) m_cnt--;
        end
        if (ex_req && !mem_ok) mcnt++;
        else mcnt = 0;
    endtask

    task automatic run();
        int start = cyc;
        while (pending() > 0 && (cyc - start) < 20000) step();
        if (pending() > 0) begin
            n_err++;
            $display("FAIL R3 watchdog (lat %0d): actual %0d ops pending expected 0", LAT, pending());
            for (int i = 0; i < NREQ; i++) oq[i].delete();
        end
        step();
        step();
    endtask

    initial begin
        done = 1'b0; n_vec = 0; n_err = 0; cyc = 0;
        req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
        mem_ok = 1'b0; mem_rline = '0;
        m_owner = -1; m_cnt = LAT; mcnt = 0;
        for (int i = 0; i < 32; i++) begin m_tag[i] = -1; m_dirty[i] = 0; m_line[i] = '0; end
        @(posedge rst_n);
        @(negedge clk);
        #1;
        chk("R2", "status after reset", LW'(resp), '0);
        chk("R2", "mem_req after reset", LW'(mem_req), '0);
        chk("R2", "rd_line after reset", rd_line, '0);
        // R3 R11: simultaneous writes to one line, lowest index owns, other hits after
        put(0, 1, 0, 32'hA0A0_0001);
        put(1, 1, 1, 32'hB0B0_0002);
        run();
        // R11: waiter on a different index does its own fill
        put(0, 1, 8, 32'hC0C0_0003);
        put(1, 0, 12, 0);
        run();
        // R6 R8: read merged line back, no memory traffic on hit
        put(2, 0, 0, 0);
        run();
        // R9: same index, new tag, dirty victim written back then filled
        put(1, 0, (1 << 7) | 2, 0);
        run();
        // R9: re-read of evicted line returns written-back words
        put(2, 0, 3, 0);
        run();
        // Mixed stream over three tags and four indexes
        for (int n = 0; n < 60; n++) begin
            put(n % 3, bit'($urandom_range(0, 1)),
                int'(($urandom_range(0, 2) << 7) | ($urandom_range(0, 3) << 2) | $urandom_range(0, 3)),
                $urandom);
        end
        run();
        done = 1'b1;
    end

endmodule

// File: tb/dm_wb_cache_bench.sv
// Bench top: two environments at hit latencies 0 and 2, 250 MHz clock.
module dm_wb_cache_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_a, done_b;
    int   vec_a, err_a, vec_b, err_b;
    int   fails;

    always #2 clk = ~clk;

    dm_wb_cache_env #(.LAT(0), .MLAT(2)) u_env_lat0 (
        .clk(clk), .rst_n(rst_n), .done(done_a), .n_vec(vec_a), .n_err(err_a));

    dm_wb_cache_env #(.LAT(2), .MLAT(3)) u_env_lat2 (
        .clk(clk), .rst_n(rst_n), .done(done_b), .n_vec(vec_b), .n_err(err_b));

    initial begin
        int wd = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (!(done_a && done_b) && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        fails = err_a + err_b;
        if (!(done_a && done_b)) begin
            fails++;
            $display("FAIL R3 bench watchdog: actual done %0d%0d expected 11", done_a, done_b);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vec_a + vec_b, fails);
        $finish;
    end

endmodule